// File: doc/BRIEF.md
# Merged Three-Stage Comb Decimator

This block lowers the sample rate of a signed stream by the product D1·D2·D3 in three successive steps. Each step is a cascade of boxcar (all-ones) comb filters followed by a subsampler. The first step uses M1 sections of length D1, the second M2 sections of length D2 and the third M3 sections of length D3. The defaults are 3, 4 and 5 sections, because the later steps need more attenuation. No multiplier is used. Each section is one running-sum accumulator before its subsampler and one first-difference after it.

The steps are merged. A first-difference that closes one step and an accumulator that opens the next run at the same rate, so they cancel, and the pair is not built. What remains is the following chain:
- M1 accumulators at the input rate;
- M2−M1 accumulators after the first subsampler;
- M3−M2 accumulators after the second subsampler;
- M3 first-differences at the output rate.

The output samples equal those of the full unmerged cascade, taken at the last input sample of every group of D1·D2·D3 accepted samples. All arithmetic is two's complement and wraps, so the integrators may overflow freely. A sample is accepted only in a cycle where its valid strobe is high.

Top module: `cic_merge_decim`

## Requirements
- R1: While reset is asserted, and after it until the first complete group, out_valid is 0 and out_data is 0 whatever the inputs do.
- R2: out_valid pulses high for exactly one cycle, in the cycle after the clock edge that accepts the D1·D2·D3-th, 2·D1·D2·D3-th, … input sample since reset, and at no other time.
- R3: For an impulse input, the output sequence equals the impulse response of the unmerged cascade. That cascade is M1 boxcars of length D1, M2 boxcars of length D2 with taps D1 apart, and M3 boxcars of length D3 with taps D1·D2 apart. It is sampled at input index m·D1·D2·D3 + D1·D2·D3 − 1.
- R4: For a constant input c, the settled output equals c·D1^M1·D2^M2·D3^M3.
- R5: out_data is OW = IW + M1·⌈log2 D1⌉ + M2·⌈log2 D2⌉ + M3·⌈log2 D3⌉ bits wide. The output is exact even when the internal accumulators wrap around, including full-scale negative input held for long runs.
- R6: Cycles with in_valid low have no effect: the value of in_data in those cycles does not change any later output, and out_data holds its value between strobes.
- R7: For arbitrary signed input, every output sample equals the unmerged cascade model of R3 reduced modulo 2^OW as a signed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IW | Signed input sample |
| out_valid | output | 1 | One-cycle strobe per decimated output |
| out_data | output | OW | Signed decimated output sample |

## Verification
The hardest case to reach is heavy accumulator wraparound. The third-order input-rate integrators must overflow many times, and the first-differences must still recover the exact output. Only a long run of extreme input gets there. The bench therefore holds the most negative input value for forty output groups. It compares every output against a wrapped convolution with the cascade's impulse response, which the bench builds independently. A second hard case is sample acceptance with gaps. This is reached by withholding in_valid at random cycles while driving junk on in_data.

// File: rtl/cic_merge_pkg.sv
package cic_merge_pkg;

   // Worst-case bit growth of the full cascade: each boxcar of length d adds ceil(log2 d).
   function automatic int growth_bits(input int d1, input int d2, input int d3,
                                      input int m1, input int m2, input int m3);
      return m1 * $clog2(d1) + m2 * $clog2(d2) + m3 * $clog2(d3);
   endfunction

endpackage

// File: rtl/rate_gen.sv
module rate_gen #(
   parameter int RATIO = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
   localparam logic [CW-1:0] TOP = CW'(RATIO - 1);

   logic [CW-1:0] cnt;

   assign tick = en && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= TOP;
      end else if (en) begin
         if (cnt == '0) cnt <= TOP;
         else           cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/integ_chain.sv
module integ_chain #(
   parameter int W = 16,
   parameter int N = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic signed [W-1:0] din,
   output logic signed [W-1:0] dout
);
   generate
      if (N == 0) begin : g_pass
         assign dout = din;
      end else begin : g_acc
         logic signed [W-1:0] st [N];
         logic signed [W-1:0] nx [N+1];
         assign nx[0] = din;
         for (genvar i = 0; i < N; i++) begin : g_sec
            assign nx[i+1] = st[i] + nx[i];
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)  st[i] <= '0;
               else if (en) st[i] <= nx[i+1];
            end
         end
         assign dout = nx[N];
      end
   endgenerate
endmodule

// File: rtl/diff_chain.sv
module diff_chain #(
   parameter int W = 16,
   parameter int N = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic signed [W-1:0] din,
   output logic signed [W-1:0] dout
);
   generate
      if (N == 0) begin : g_pass
         assign dout = din;
      end else begin : g_dif
         logic signed [W-1:0] prev [N];
         logic signed [W-1:0] nx   [N+1];
         assign nx[0] = din;
         for (genvar i = 0; i < N; i++) begin : g_sec
            assign nx[i+1] = nx[i] - prev[i];
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)  prev[i] <= '0;
               else if (en) prev[i] <= nx[i];
            end
         end
         assign dout = nx[N];
      end
   endgenerate
endmodule

// File: rtl/cic_merge_decim.sv
module cic_merge_decim #(
   parameter int IW = 8,
   parameter int D1 = 4,
   parameter int D2 = 2,
   parameter int D3 = 2,
   parameter int M1 = 3,
   parameter int M2 = 4,
   parameter int M3 = 5,
   localparam int OW = IW + cic_merge_pkg::growth_bits(D1, D2, D3, M1, M2, M3)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic signed [IW-1:0] in_data,
   output logic                 out_valid,
   output logic signed [OW-1:0] out_data
);
   localparam int W = OW;

   // Elaboration-time parameter checks
   if (D1 < 2 || D2 < 2 || D3 < 2) begin : g_bad_ratio
      $error("cic_merge_decim: every ratio must be at least 2");
   end
   if (M1 < 1 || M2 < M1 || M3 < M2) begin : g_bad_order
      $error("cic_merge_decim: section counts must satisfy 1 <= M1 <= M2 <= M3");
   end

   logic                tick1, tick2, tick3;
   logic signed [W-1:0] x_ext, s0, s1, s2, s3;

   assign x_ext = {{(W-IW){in_data[IW-1]}}, in_data};

   rate_gen #(.RATIO(D1)) u_rate1 (.clk(clk), .rst_n(rst_n), .en(in_valid), .tick(tick1));
   rate_gen #(.RATIO(D2)) u_rate2 (.clk(clk), .rst_n(rst_n), .en(tick1),    .tick(tick2));
   rate_gen #(.RATIO(D3)) u_rate3 (.clk(clk), .rst_n(rst_n), .en(tick2),    .tick(tick3));

   integ_chain #(.W(W), .N(M1)) u_int0 (
      .clk(clk), .rst_n(rst_n), .en(in_valid), .din(x_ext), .dout(s0));
   integ_chain #(.W(W), .N(M2 - M1)) u_int1 (
      .clk(clk), .rst_n(rst_n), .en(tick1), .din(s0), .dout(s1));
   integ_chain #(.W(W), .N(M3 - M2)) u_int2 (
      .clk(clk), .rst_n(rst_n), .en(tick2), .din(s1), .dout(s2));
   diff_chain #(.W(W), .N(M3)) u_diff (
      .clk(clk), .rst_n(rst_n), .en(tick3), .din(s2), .dout(s3));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= tick3;
         if (tick3) out_data <= s3;
      end
   end
endmodule

// File: rtl/cic_merge_chk.sv
module cic_merge_chk #(
   parameter int TOTAL = 16,
   parameter int OW    = 23
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          out_valid,
   input logic [OW-1:0] out_data
);
   localparam int CW = $clog2(TOTAL) + 1;

   logic [CW-1:0] acc_cnt;
   logic          exp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_cnt <= '0;
         exp_q   <= 1'b0;
      end else begin
         exp_q <= in_valid && (acc_cnt == CW'(TOTAL - 1));
         if (in_valid) acc_cnt <= (acc_cnt == CW'(TOTAL - 1)) ? '0 : acc_cnt + 1'b1;
      end
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && out_data == '0));

   assert_pulse_grid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == exp_q);

   assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   assert_needs_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

   assert_hold_between_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_data));
endmodule

bind cic_merge_decim cic_merge_chk #(.TOTAL(D1 * D2 * D3), .OW(OW)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
   .out_valid(out_valid), .out_data(out_data));

// File: tb/test_cic_merge_decim.sv
`timescale 1ns/1ps
module test_cic_merge_decim;
   localparam int IW = 8, D1 = 4, D2 = 2, D3 = 2, M1 = 3, M2 = 4, M3 = 5;
   localparam int DT = D1 * D2 * D3;
   localparam int W  = IW + M1 * $clog2(D1) + M2 * $clog2(D2) + M3 * $clog2(D3);
   localparam int HMAX = 256;
   localparam int MAXN = 1024;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                in_valid = 1'b0;
   logic signed [IW-1:0] in_data = '0;
   logic                out_valid;
   logic signed [W-1:0] out_data;

   always #2.5 clk = ~clk;

   cic_merge_decim #(.IW(IW), .D1(D1), .D2(D2), .D3(D3), .M1(M1), .M2(M2), .M3(M3))
      i_cic_merge_decim (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
                         .out_valid(out_valid), .out_data(out_data));

   int     h [HMAX];
   int     hlen;
   int     xs [MAXN];
   longint got [MAXN];
   int     ngot;
   int     nchk = 0;
   int     nfail = 0;
   bit     timing_bad;
   bit     prev_fire;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic void add_section(input int sp, input int len);
      int tmp [HMAX];
      int nlen = hlen + (len - 1) * sp;
      for (int i = 0; i < nlen; i++) begin
         tmp[i] = 0;
         for (int j = 0; j < len; j++)
            if (i - j * sp >= 0 && i - j * sp < hlen) tmp[i] += h[i - j * sp];
      end
      for (int i = 0; i < nlen; i++) h[i] = tmp[i];
      hlen = nlen;
   endfunction

   function automatic void build_h();
      for (int i = 0; i < HMAX; i++) h[i] = 0;
      h[0] = 1;
      hlen = 1;
      for (int k = 0; k < M1; k++) add_section(1, D1);
      for (int k = 0; k < M2; k++) add_section(D1, D2);
      for (int k = 0; k < M3; k++) add_section(D1 * D2, D3);
   endfunction

   function automatic longint model(input int m);
      longint acc = 0;
      int     n = m * DT + DT - 1;
      logic signed [W-1:0] t;
      for (int k = 0; k < hlen; k++)
         if (n - k >= 0) acc += longint'(h[k]) * longint'(xs[n - k]);
      t = acc[W-1:0];
      return longint'(t);
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      in_valid = 1'b0;
      prev_fire = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic sample_out();
      if (out_valid !== prev_fire) timing_bad = 1'b1;
      if (out_valid === 1'b1) begin
         got[ngot] = longint'(out_data);
         ngot++;
      end
   endtask

   task automatic run_stream(input string req, input int n, input int gap_pct);
      int i = 0;
      int acc_cnt = 0;
      do_reset();
      ngot = 0;
      timing_bad = 1'b0;
      while (i < n) begin
         @(negedge clk);
         sample_out();
         if (gap_pct > 0 && ($urandom % 100) < gap_pct) begin
            in_valid = 1'b0;
            in_data = IW'($urandom);
            prev_fire = 1'b0;
         end else begin
            in_valid = 1'b1;
            in_data = IW'(xs[i]);
            i++;
            acc_cnt++;
            prev_fire = (acc_cnt % DT == 0);
         end
      end
      @(negedge clk);
      sample_out();
      in_valid = 1'b0;
      in_data = '0;
      prev_fire = 1'b0;
      repeat (4) begin
         @(negedge clk);
         sample_out();
      end
      check(ngot == n / DT, "R2", "output count", ngot, n / DT);
      check(!timing_bad, "R2", "strobe one cycle after each group end", timing_bad, 0);
      for (int m = 0; m < ngot && m < n / DT; m++)
         check(got[m] == model(m), req, $sformatf("sample %0d", m), got[m], model(m));
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      in_valid = 1'b1;
      in_data = 8'sd55;
      repeat (3) begin
         @(negedge clk);
         check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
         check(out_data == '0, "R1", "out_data in reset", out_data, 0);
      end
      in_valid = 1'b0;
      rst_n = 1'b1;
      repeat (50) begin
         in_data = IW'($urandom);
         @(negedge clk);
      end
      check(out_valid == 1'b0, "R6", "idle cycles make no output", out_valid, 0);
      check(out_data == '0, "R1", "out_data after idle", out_data, 0);
   endtask

   task automatic t_impulse();
      for (int i = 0; i < MAXN; i++) xs[i] = 0;
      xs[3] = 1;
      xs[90] = -1;
      run_stream("R3", DT * 12, 0);
   endtask

   task automatic t_step();
      longint gain = 1;
      for (int i = 0; i < M1; i++) gain *= D1;
      for (int i = 0; i < M2; i++) gain *= D2;
      for (int i = 0; i < M3; i++) gain *= D3;
      for (int i = 0; i < MAXN; i++) xs[i] = 127;
      run_stream("R4", DT * 10, 0);
      check(got[9] == 127 * gain, "R4", "settled constant output", got[9], 127 * gain);
   endtask

   task automatic t_negfull();
      longint gain = 1;
      for (int i = 0; i < M1; i++) gain *= D1;
      for (int i = 0; i < M2; i++) gain *= D2;
      for (int i = 0; i < M3; i++) gain *= D3;
      for (int i = 0; i < MAXN; i++) xs[i] = -128;
      run_stream("R5", DT * 40, 0);
      check(got[39] == -128 * gain, "R5", "full-scale negative after wraps", got[39], -128 * gain);
   endtask

   task automatic t_random();
      for (int i = 0; i < MAXN; i++) xs[i] = int'($urandom % 256) - 128;
      run_stream("R7", DT * 30, 0);
   endtask

   task automatic t_gaps();
      for (int i = 0; i < MAXN; i++) xs[i] = int'($urandom % 256) - 128;
      run_stream("R6", DT * 20, 40);
   endtask

   initial begin
      #(200000 * 5);
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      build_h();
      t_reset();
      t_impulse();
      t_step();
      t_negfull();
      t_random();
      t_gaps();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule